// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This block gathers three interrupt sources into one 8-bit control register and raises an interrupt request and a wake request for a small processor core.

- **External pin.** It is edge triggered. A separate polarity input selects which edge counts.
- **Timer rollover.** This is a single-cycle pulse that the timer raises when it rolls over.
- **Port change.** This is a change detector on a narrow input port.

Each source sets its own sticky flag bit, and the flag stays set until software writes it back to zero. Software reads and writes the whole register through a simple one-cycle write port, and the read data is always visible.

Each flag is qualified by its own enable bit. The interrupt request also needs the global enable bit. The wake request does not use the global enable, so a core in sleep wakes on any enabled, flagged source. Whether it then branches to a handler depends on the global enable.

The pin inputs are first passed through a synchronizer chain. The port-change detector compares the synchronized port against a reference value. That compare, and the reference update, happen only on the instruction-cycle strobe, so a change that does not last until the next strobe is not seen.

Top module: `intr_flag_unit`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and both `irq_req` and `wake_req` are low.
- R2: The enable bits are software read/write: bit 7 global, bit 5 timer, bit 4 external pin, bit 3 port change. Bit 6 always reads 0.
- R3: With `edge_rise_sel`=1, a 0-to-1 transition on `ext_pin` sets flag bit 1 within four clocks, and a 1-to-0 transition sets nothing.
- R4: With `edge_rise_sel`=0, a 1-to-0 transition on `ext_pin` sets flag bit 1, and a 0-to-1 transition sets nothing. Changing `edge_rise_sel` while the pin is steady sets nothing.
- R5: A one-clock pulse on `tmr_ovf` sets flag bit 2 on the next clock edge.
- R6: At each `cyc_tick`, if the synchronized `port_in` differs from the reference, flag bit 0 is set and the reference is reloaded. The first tick after reset only loads the reference. A change that is gone again before the next tick is not recognized.
- R7: A set flag (bits 2..0) stays set until a write with a 0 in that bit position.
- R8: A write with 1 in a flag position sets that flag. A hardware set in the same cycle as a software write of 0 leaves the flag at 1.
- R9: `irq_req` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0)).
- R10: `wake_req` = (bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0), whatever the value of bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock strobe per instruction cycle |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| edge_rise_sel | input | 1 | 1 selects the rising edge, 0 the falling edge |
| tmr_ovf | input | 1 | Timer rollover pulse |
| port_in | input | PORT_W | Change-monitored input port (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
The in-line assertions check four things on every cycle:
- A set flag holds while no write occurs.
- A detected pin edge or timer pulse is latched on the next edge, even against a software clear.
- A software write of 1 sets its flag.
- A request is never raised without the wake condition, and port changes are flagged only on a strobe.

Only the bench scenarios can show the behaviour that depends on what comes before an event:
- the edge polarity choice, and that the opposite edge is ignored;
- that the first strobe after reset only loads the reference, and that a short port glitch between strobes is lost;
- the split between the interrupt request and the wake request as the global enable changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int CTL_W    = 8;
   localparam int B_GIE    = 7;
   localparam int B_RSV    = 6;
   localparam int B_TMR_EN = 5;
   localparam int B_EXT_EN = 4;
   localparam int B_CHG_EN = 3;
   localparam int B_TMR_FL = 2;
   localparam int B_EXT_FL = 1;
   localparam int B_CHG_FL = 0;
   localparam int N_SRC    = 3;
   localparam logic [CTL_W-1:0] CTL_MASK = ~(CTL_W'(1) << B_RSV);

   typedef struct packed {
      logic tmr;
      logic ext;
      logic chg;
   } src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2) else $error("irq_sync: STAGES must be at least 2");
   initial assert (W >= 1) else $error("irq_sync: W must be at least 1");

   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
   parameter bit BOTH_EDGES = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic rise_sel,
   output logic hit
);
   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;

   generate
      if (BOTH_EDGES) begin : g_both
         assign hit = rise | fall;
      end else begin : g_sel
         assign hit = rise_sel ? rise : fall;
      end
   endgenerate

   // R3
   one_edge_per_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
   parameter int W       = 4,
   parameter bit ON_TICK = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] port,
   output logic         changed
);
   initial assert (W >= 1) else $error("irq_chg_det: W must be at least 1");

   logic [W-1:0] ref_q;
   logic         ref_ok_q;
   logic         sample;

   generate
      if (ON_TICK) begin : g_tick
         assign sample = tick;
      end else begin : g_every
         assign sample = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q    <= '0;
         ref_ok_q <= 1'b0;
      end else if (sample) begin
         ref_q    <= port;
         ref_ok_q <= 1'b1;
      end
   end

   assign changed = sample & ref_ok_q & (port != ref_q);

   generate
      if (ON_TICK) begin : g_tick_chk
         // R6
         chg_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            changed |-> tick);
      end
   endgenerate
endmodule

// File: rtl/intr_flag_unit.sv
module intr_flag_unit
   import irq_pkg::*;
#(
   parameter int PORT_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit CHG_ON_TICK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_tick,
   input  logic              ext_pin,
   input  logic              edge_rise_sel,
   input  logic              tmr_ovf,
   input  logic [PORT_W-1:0] port_in,
   input  logic              wr_en,
   input  logic [CTL_W-1:0]  wr_data,
   output logic [CTL_W-1:0]  rd_data,
   output logic              irq_req,
   output logic              wake_req
);
   initial assert (PORT_W >= 1 && PORT_W <= 32) else $error("intr_flag_unit: PORT_W out of range");

   logic              ext_s;
   logic [PORT_W-1:0] port_s;
   src_vec_t          hw_set;
   src_vec_t          flags;
   src_vec_t          enables;
   logic [CTL_W-1:0]  ctl_q;
   logic [CTL_W-1:0]  ctl_d;
   logic [CTL_W-1:0]  hw_mask;

   irq_sync #(.W(1), .STAGES(SYNC_STAGES)) i_ext_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s));

   irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_port_sync (
      .clk(clk), .rst_n(rst_n), .d(port_in), .q(port_s));

   irq_edge_det #(.BOTH_EDGES(1'b0)) i_edge (
      .clk(clk), .rst_n(rst_n), .sig(ext_s), .rise_sel(edge_rise_sel), .hit(hw_set.ext));

   irq_chg_det #(.W(PORT_W), .ON_TICK(CHG_ON_TICK)) i_chg (
      .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .port(port_s), .changed(hw_set.chg));

   assign hw_set.tmr = tmr_ovf;

   always_comb begin
      hw_mask = '0;
      hw_mask[B_TMR_FL] = hw_set.tmr;
      hw_mask[B_EXT_FL] = hw_set.ext;
      hw_mask[B_CHG_FL] = hw_set.chg;
   end

   always_comb begin
      ctl_d = wr_en ? wr_data : ctl_q;
      ctl_d = (ctl_d | hw_mask) & CTL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   assign flags.tmr   = ctl_q[B_TMR_FL];
   assign flags.ext   = ctl_q[B_EXT_FL];
   assign flags.chg   = ctl_q[B_CHG_FL];
   assign enables.tmr = ctl_q[B_TMR_EN];
   assign enables.ext = ctl_q[B_EXT_EN];
   assign enables.chg = ctl_q[B_CHG_EN];

   assign wake_req = |(flags & enables);
   assign irq_req  = ctl_q[B_GIE] & wake_req;
   assign rd_data  = ctl_q;

   // R7
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && flags.ext) |=> flags.ext);
   // R5
   tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> rd_data[B_TMR_FL]);
   // R3
   ext_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set.ext |=> rd_data[B_EXT_FL]);
   // R8
   sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[B_CHG_FL]) |=> rd_data[B_CHG_FL]);
   // R9
   irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (wake_req && rd_data[B_GIE]));
   // R2
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[B_RSV]) |=> !rd_data[B_RSV]);
endmodule

// File: tb/test_intr_flag_unit.sv
module test_intr_flag_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_tick = 1'b0;
   logic       ext_pin = 1'b0;
   logic       edge_rise_sel = 1'b1;
   logic       tmr_ovf = 1'b0;
   logic [3:0] port_in = 4'h0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq_req;
   logic       wake_req;

   int  n_chk = 0;
   int  n_fail = 0;
   int  tcnt = 0;
   bit  tick_en = 1'b0;

   always #10 clk = ~clk;

   intr_flag_unit i_intr_flag_unit (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
      .edge_rise_sel(edge_rise_sel), .tmr_ovf(tmr_ovf), .port_in(port_in),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .irq_req(irq_req), .wake_req(wake_req));

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tcnt++;
         cyc_tick = tick_en && (tcnt % 4 == 0);
      end
   endtask

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] v);
      wr_en = 1'b1;
      wr_data = v;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic do_reset(input logic [3:0] port_val);
      tick_en = 1'b0;
      port_in = port_val;
      rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(4);
      tick_en = 1'b1;
   endtask

   task automatic t_reset;
      do_reset(4'h0);
      check("R1 rd_data", rd_data, 8'h00);
      check("R1 irq_req", {7'b0, irq_req}, 8'h00);
      check("R1 wake_req", {7'b0, wake_req}, 8'h00);
   endtask

   task automatic t_enables;
      reg_write(8'hF8);
      check("R2 enables written, bit6 zero", rd_data, 8'hB8);
      reg_write(8'h00);
      check("R2 enables cleared", rd_data, 8'h00);
   endtask

   task automatic t_ext_rise;
      edge_rise_sel = 1'b1;
      ext_pin = 1'b1;
      step(4);
      check("R3 rising edge sets bit1", rd_data, 8'h02);
      reg_write(8'h00);
      ext_pin = 1'b0;
      step(5);
      check("R3 falling edge ignored", rd_data, 8'h00);
   endtask

   task automatic t_ext_fall;
      edge_rise_sel = 1'b0;
      step(3);
      check("R4 select change on steady pin", rd_data, 8'h00);
      ext_pin = 1'b1;
      step(5);
      check("R4 rising edge ignored", rd_data, 8'h00);
      ext_pin = 1'b0;
      step(4);
      check("R4 falling edge sets bit1", rd_data, 8'h02);
      reg_write(8'h00);
      edge_rise_sel = 1'b1;
      step(2);
   endtask

   task automatic t_timer;
      tmr_ovf = 1'b1;
      step(1);
      tmr_ovf = 1'b0;
      check("R5 timer pulse sets bit2", rd_data, 8'h04);
      step(6);
      check("R7 timer flag sticky", rd_data, 8'h04);
      reg_write(8'h00);
      check("R7 write 0 clears flag", rd_data, 8'h00);
   endtask

   task automatic t_hw_vs_sw;
      tmr_ovf = 1'b1;
      wr_en = 1'b1;
      wr_data = 8'h00;
      step(1);
      tmr_ovf = 1'b0;
      wr_en = 1'b0;
      check("R8 hw set beats sw clear", rd_data, 8'h04);
      reg_write(8'h01);
      check("R8 sw write 1 sets flag", rd_data, 8'h01);
      reg_write(8'h00);
   endtask

   task automatic t_port;
      port_in = 4'h3;
      step(10);
      check("R6 port change sets bit0", rd_data, 8'h01);
      reg_write(8'h00);
      step(10);
      check("R6 no change no flag", rd_data, 8'h00);
      tick_en = 1'b0;
      step(1);
      port_in = 4'h7;
      step(1);
      port_in = 4'h3;
      step(6);
      tick_en = 1'b1;
      step(10);
      check("R6 glitch between ticks ignored", rd_data, 8'h00);
   endtask

   task automatic t_first_tick;
      do_reset(4'h5);
      step(12);
      check("R6 first tick loads reference only", rd_data, 8'h00);
   endtask

   task automatic t_req;
      reg_write(8'h10);
      ext_pin = 1'b1;
      step(4);
      check("R10 wake without global enable", {6'b0, wake_req, irq_req}, 8'h02);
      reg_write(8'h92);
      check("R9 irq with global enable", {6'b0, wake_req, irq_req}, 8'h03);
      reg_write(8'h82);
      check("R9 flag without its enable", {6'b0, wake_req, irq_req}, 8'h00);
      reg_write(8'hA2);
      check("R10 other enable does not wake", {6'b0, wake_req, irq_req}, 8'h00);
      reg_write(8'h00);
      ext_pin = 1'b0;
      step(4);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_enables();
      t_ext_rise();
      t_ext_fall();
      t_timer();
      t_hw_vs_sw();
      t_port();
      t_req();
      t_first_tick();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule